// File: doc/BRIEF.md
# Parallel Bit-Vector Set Engine

This block keeps a set of small integers as a membership vector of `W` flag bits, where flag `i` high means the integer `i` belongs to the set. A single request changes every flag at once, in one clock cycle. A request can load or clear the set, merge it with an operand vector, filter it against numeric bounds, or replace every member by its quotient or remainder with a divisor.

The stored vector is meant to be shown on screen while the beam is in the visible area. For that reason, a change is written only on a clock edge where the `blank` input is high. A request that arrives while `blank` is low waits in a single holding slot. A newer request replaces the waiting one. The waiting request runs on the first edge with `blank` high. A request presented together with `blank` high takes effect on that same edge. Two flags are decoded without registers from the stored vector: one reports an empty set, the other a full set.

Top module: `bitset_engine`

## Requirements
- R1: On a clock edge with `rst_n` low, `set_q` becomes all zeros, `div_err` becomes 0 and any waiting request is discarded.
- R2: Flag `i` of `set_q` stands for integer `i`, for 0 ≤ i < W. `set_empty` is 1 exactly when `set_q` is all zeros. `set_full` is 1 exactly when `set_q` is all ones. Both flags follow `set_q` in the same cycle.
- R3: `req_op` value 0 replaces the set with `req_mask`. Value 1 empties the set.
- R4: `req_op` value 2 ORs `req_mask` into the set (union). Value 3 ANDs the set with `req_mask` (intersection).
- R5: `req_op` value 4 keeps only members n < `req_a`. Value 5 keeps only members n > `req_a`.
- R6: `req_op` value 6 keeps only members with `req_a` ≤ n ≤ `req_b`. Value 7 keeps only members with n < `req_a` or n > `req_b`.
- R7: `req_op` value 8 maps every member n to n / `req_a`, rounding down. Value 9 maps every member n to n mod `req_a`. The new set is the OR of all the images.
- R8: When value 8 or 9 is committed with `req_a` = 0, the set is left unchanged. `div_err` is then high for exactly the one cycle after that edge.
- R9: `set_q` changes only on an edge where `blank` is high. While `blank` is low it holds its value.
- R10: A request made while `blank` is low waits, and only the most recent such request is kept. It runs on the first edge where `blank` is high. A request presented with `blank` high runs on that same edge.
- R11: `req_op` values 10 to 15 leave the set unchanged and never raise `div_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blank | input | 1 | High during the blanking interval; enables commits |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 4 | Operation code (see R3 to R7, R11) |
| req_mask | input | W | Operand vector for load, union and intersection |
| req_a | input | $clog2(W) | Low bound, threshold or divisor |
| req_b | input | $clog2(W) | High bound for the inside and outside filters |
| set_q | output | W | Stored membership vector |
| set_empty | output | 1 | Set holds no member |
| set_full | output | 1 | Set holds every integer 0..W-1 |
| div_err | output | 1 | One-cycle pulse after a divide or modulo by zero |

## Verification
The bench sweeps starting sets, every operation and every operand value, and compares each result with a model that works on each integer arithmetically. Range bounds are included where `req_b` is below `req_a`. A design that treats the bounds as exclusive, or that shifts the vector instead of mapping each member, would give the wrong set. Divisor 0 is tested directly: a design that divides anyway would corrupt the set, and one that holds the error flag would keep `div_err` high into the next cycle. The gating cases hold `blank` low across several cycles and present two requests. A design that commits early would change the set while it is on screen. One that keeps the first request would show the older result. One that keeps the waiting request through reset would apply a stale operation.

// File: rtl/bitset_pkg.sv
// Shared definitions for the bit-vector set engine.
// Assumes operation codes are 4 bits wide; codes without a name are no-ops.
package bitset_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 4'd0,
        OP_CLEAR   = 4'd1,
        OP_UNION   = 4'd2,
        OP_ISECT   = 4'd3,
        OP_BELOW   = 4'd4,
        OP_ABOVE   = 4'd5,
        OP_INSIDE  = 4'd6,
        OP_OUTSIDE = 4'd7,
        OP_DIV     = 4'd8,
        OP_MOD     = 4'd9
    } op_e;

endpackage

// File: rtl/bitset_req_hold.sv
// Single-slot holding register for set requests.
// The live request takes priority over the stored one. A request is stored
// whenever it is not consumed, overwriting any older one. Assumes 'consume'
// is asserted only while cur_valid is high.
module bitset_req_hold
    import bitset_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_mask,
    input  logic [IW-1:0]   in_a,
    input  logic [IW-1:0]   in_b,
    input  logic            consume,
    output logic            cur_valid,
    output logic [OP_W-1:0] cur_op,
    output logic [W-1:0]    cur_mask,
    output logic [IW-1:0]   cur_a,
    output logic [IW-1:0]   cur_b
);

    logic            pend_v;
    logic [OP_W-1:0] pend_op;
    logic [W-1:0]    pend_mask;
    logic [IW-1:0]   pend_a;
    logic [IW-1:0]   pend_b;

    // Select the live request when present, else the waiting one
    always_comb begin
        cur_valid = in_valid | pend_v;
        cur_op    = in_valid ? in_op   : pend_op;
        cur_mask  = in_valid ? in_mask : pend_mask;
        cur_a     = in_valid ? in_a    : pend_a;
        cur_b     = in_valid ? in_b    : pend_b;
    end

    // Keep the newest unconsumed request; drop it when consumed or on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_op   <= '0;
            pend_mask <= '0;
            pend_a    <= '0;
            pend_b    <= '0;
        end else if (consume) begin
            pend_v    <= 1'b0;
        end else if (in_valid) begin
            pend_v    <= 1'b1;
            pend_op   <= in_op;
            pend_mask <= in_mask;
            pend_a    <= in_a;
            pend_b    <= in_b;
        end
    end

    AST_CONSUME_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> cur_valid);                                          // R10
    AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !pend_v);                                            // R10

endmodule

// File: rtl/bitset_alu.sv
// Combinational next-set computation for every operation.
// Each flag is evaluated in parallel. Range filters are built per bit with
// generate. Divide and modulo scatter each member into its image bit.
// Assumes W >= 2. Unknown codes and a zero divisor return the input set.
module bitset_alu
    import bitset_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]    set_in,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    mask,
    input  logic [IW-1:0]   a,
    input  logic [IW-1:0]   b,
    output logic [W-1:0]    set_out,
    output logic            zero_div
);

    logic [W-1:0] lt_a, gt_a, le_b, gt_b;
    logic [W-1:0] div_img, mod_img;

    // Per-bit comparison of each integer against the bounds
    for (genvar g = 0; g < W; g++) begin : g_cmp
        localparam logic [IW-1:0] IDX = IW'(g);
        assign lt_a[g] = IDX <  a;
        assign gt_a[g] = IDX >  a;
        assign le_b[g] = IDX <= b;
        assign gt_b[g] = IDX >  b;
    end

    // Scatter each member to its quotient and remainder positions
    always_comb begin
        div_img = '0;
        mod_img = '0;
        if (a != '0) begin
            for (int i = 0; i < W; i++) begin
                if (set_in[i]) begin
                    div_img[IW'(i / int'(a))] = 1'b1;
                    mod_img[IW'(i % int'(a))] = 1'b1;
                end
            end
        end
    end

    assign zero_div = ((op == OP_DIV) || (op == OP_MOD)) && (a == '0);

    // Choose the result for the requested operation
    always_comb begin
        case (op)
            OP_LOAD:    set_out = mask;
            OP_CLEAR:   set_out = '0;
            OP_UNION:   set_out = set_in | mask;
            OP_ISECT:   set_out = set_in & mask;
            OP_BELOW:   set_out = set_in & lt_a;
            OP_ABOVE:   set_out = set_in & gt_a;
            OP_INSIDE:  set_out = set_in & ~lt_a & le_b;
            OP_OUTSIDE: set_out = set_in & (lt_a | gt_b);
            OP_DIV:     set_out = zero_div ? set_in : div_img;
            OP_MOD:     set_out = zero_div ? set_in : mod_img;
            default:    set_out = set_in;
        endcase
    end

endmodule

// File: rtl/bitset_engine.sv
// Bit-vector set engine top.
// Holds the membership vector and commits the selected request only on edges
// where blank is high. Assumes blank is synchronous to clk.
module bitset_engine
    import bitset_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blank,
    input  logic            req_valid,
    input  logic [OP_W-1:0] req_op,
    input  logic [W-1:0]    req_mask,
    input  logic [IW-1:0]   req_a,
    input  logic [IW-1:0]   req_b,
    output logic [W-1:0]    set_q,
    output logic            set_empty,
    output logic            set_full,
    output logic            div_err
);

    logic            cur_valid;
    logic [OP_W-1:0] cur_op;
    logic [W-1:0]    cur_mask;
    logic [IW-1:0]   cur_a, cur_b;
    logic [W-1:0]    alu_out;
    logic            zero_div;
    logic            commit;

    assign commit = blank & cur_valid;

    bitset_req_hold #(.W(W), .IW(IW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_op     (req_op),
        .in_mask   (req_mask),
        .in_a      (req_a),
        .in_b      (req_b),
        .consume   (commit),
        .cur_valid (cur_valid),
        .cur_op    (cur_op),
        .cur_mask  (cur_mask),
        .cur_a     (cur_a),
        .cur_b     (cur_b)
    );

    bitset_alu #(.W(W), .IW(IW)) u_alu (
        .set_in   (set_q),
        .op       (cur_op),
        .mask     (cur_mask),
        .a        (cur_a),
        .b        (cur_b),
        .set_out  (alu_out),
        .zero_div (zero_div)
    );

    // Store the new set on a blanking commit and flag a zero divisor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q   <= '0;
            div_err <= 1'b0;
        end else begin
            div_err <= commit & zero_div;
            if (commit) set_q <= alu_out;
        end
    end

    // Empty and full decode straight from the stored vector
    assign set_empty = (set_q == '0);
    assign set_full  = (set_q == '1);

    AST_HOLD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |=> $stable(set_q));                                      // R9
    AST_ERR_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (set_q == $past(set_q)));                            // R8
    AST_ERR_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> $past(blank));                                       // R8
    AST_DIV_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cur_op == OP_DIV || cur_op == OP_MOD))
            |-> ($countones(alu_out) <= $countones(set_q)));             // R7
    AST_ISECT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cur_op == OP_ISECT) |-> ((alu_out & ~set_q) == '0));  // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_empty && set_full));                                       // R2

endmodule

// File: tb/bitset_engine_bench.sv
`timescale 1ns/1ps
module bitset_engine_bench;

    localparam int W  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blank = 1'b0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_op = '0;
    logic [W-1:0]  req_mask = '0;
    logic [IW-1:0] req_a = '0;
    logic [IW-1:0] req_b = '0;
    logic [W-1:0]  set_q;
    logic          set_empty, set_full, div_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bitset_engine #(.W(W), .IW(IW)) u_bitset_engine (
        .clk(clk), .rst_n(rst_n), .blank(blank), .req_valid(req_valid),
        .req_op(req_op), .req_mask(req_mask), .req_a(req_a), .req_b(req_b),
        .set_q(set_q), .set_empty(set_empty), .set_full(set_full),
        .div_err(div_err)
    );

    // Reference model: evaluate each integer arithmetically
    function automatic logic [W-1:0] model(input logic [W-1:0] s, input int op,
                                           input logic [W-1:0] m, input int a, input int b);
        logic [W-1:0] r;
        r = '0;
        case (op)
            0: r = m;
            1: r = '0;
            2: r = s | m;
            3: r = s & m;
            8, 9: begin
                if (a == 0) r = s;
                else for (int n = 0; n < W; n++)
                    if (s[n]) r[(op == 8) ? n / a : n % a] = 1'b1;
            end
            4, 5, 6, 7: begin
                for (int n = 0; n < W; n++) begin
                    bit keep;
                    keep = (op == 4) ? (n < a) :
                           (op == 5) ? (n > a) :
                           (op == 6) ? (n >= a && n <= b) : (n < a || n > b);
                    r[n] = s[n] & keep;
                end
            end
            default: r = s;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request with blank high; returns after the commit edge
    task automatic do_op(input int op, input logic [W-1:0] m, input int a, input int b);
        @(negedge clk);
        blank = 1'b1; req_valid = 1'b1; req_op = 4'(op);
        req_mask = m; req_a = IW'(a); req_b = IW'(b);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [W-1:0] exp;
        repeat (3) @(negedge clk);
        check(set_q == '0 && set_empty && !set_full && !div_err, "R1 reset", set_q, '0);
        rst_n = 1'b1;

        // R2, R3: full and empty flags with load and clear
        do_op(0, 8'hFF, 0, 0);
        check(set_q == 8'hFF && set_full && !set_empty, "R2 full", set_q, 8'hFF);
        do_op(1, 8'h00, 0, 0);
        check(set_q == 8'h00 && set_empty && !set_full, "R3 clear", set_q, 8'h00);

        // R3..R7: sweep sets, operations and operands
        for (int s = 0; s < 256; s += 5) begin
            for (int op = 2; op <= 9; op++) begin
                for (int a = 0; a < W; a++) begin
                    int b;
                    logic [W-1:0] m;
                    b = (a + s) % W;
                    m = W'(s * 3) ^ W'(a * 37);
                    do_op(0, W'(s), 0, 0);
                    do_op(op, m, a, b);
                    exp = model(W'(s), op, m, a, b);
                    check(set_q == exp, (op < 4) ? "R4 logic" : (op < 6) ? "R5 threshold" :
                          (op < 8) ? "R6 bounds" : "R7 divmod", set_q, exp);
                    check(set_empty == (exp == '0) && set_full == (exp == '1),
                          "R2 flags", {6'b0, set_empty, set_full},
                          {6'b0, exp == '0, exp == '1});
                    check(div_err == (op >= 8 && a == 0), "R8 err flag",
                          W'(div_err), W'(op >= 8 && a == 0));
                end
            end
        end

        // R8: zero-divisor pulse lasts one cycle
        do_op(0, 8'hA7, 0, 0);
        do_op(9, 8'h00, 0, 0);
        check(div_err && set_q == 8'hA7, "R8 unchanged", set_q, 8'hA7);
        @(negedge clk);
        check(!div_err, "R8 single pulse", W'(div_err), '0);

        // R11: undefined codes leave the set alone
        for (int op = 10; op < 16; op++) begin
            do_op(op, 8'h3C, 2, 5);
            check(set_q == 8'hA7 && !div_err, "R11 no-op", set_q, 8'hA7);
        end

        // R9, R10: requests outside blanking wait; latest wins
        @(negedge clk);
        blank = 1'b0; req_valid = 1'b1; req_op = 4'd2; req_mask = 8'h08;
        @(negedge clk);
        req_op = 4'd3; req_mask = 8'h21;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(set_q == 8'hA7, "R9 held while visible", set_q, 8'hA7);
        blank = 1'b1;
        @(negedge clk);
        check(set_q == (8'hA7 & 8'h21), "R10 latest pending", set_q, 8'hA7 & 8'h21);
        @(negedge clk);
        check(set_q == 8'h21, "R10 consumed once", set_q, 8'h21);

        // R1: reset drops a waiting request
        blank = 1'b0; req_valid = 1'b1; req_op = 4'd0; req_mask = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; blank = 1'b1;
        repeat (2) @(negedge clk);
        check(set_q == '0 && set_empty, "R1 pending dropped", set_q, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule